// File: doc/BRIEF.md
# Burst Address Counter

This block generates the address that one port of a synchronous RAM uses in each clock cycle. At every rising edge it takes one of four actions, chosen by three active-low controls: it clears to address zero, loads an address from outside, steps up by one, or keeps its value. The chosen address is registered. The memory then uses that registered address for the access that belongs to the same edge, so successive words of a burst come from successive locations without any help from the requester.

The controls have a fixed priority. The clear control wins over everything else. The strobe that loads an external address wins over counting. Counting is honoured only when neither of the other two controls is active. The counter covers the whole address space and overflows naturally from the top address back to zero.

Two chip-select inputs qualify the access: one is active-low and one is active-high. They are registered alongside the address and only gate the memory access. The counter ignores them completely. A clear does not insert an idle cycle, so the access that uses address zero can take place at the same edge.

Top module: `burst_addr_ctr`

## Requirements
- R1: While the synchronous active-high `rst` is sampled high at a rising edge, `mem_addr` becomes 0 and `mem_sel` becomes 0 after that edge.
- R2: With `clr_n` low at an edge, `mem_addr` is 0 after that edge, whatever the levels of `strobe_n`, `cnt_en_n` and `ext_addr`.
- R3: With `clr_n` high and `strobe_n` low at an edge, `mem_addr` equals the `ext_addr` sampled at that edge, and `cnt_en_n` has no effect.
- R4: With `clr_n` and `strobe_n` high and `cnt_en_n` low at an edge, `mem_addr` becomes its previous value plus one.
- R5: With all three controls high at an edge, `mem_addr` keeps its value, and `ext_addr` has no effect.
- R6: Counting from the top address, 2^AW-1, gives address 0.
- R7: The levels of `sel_n` and `sel` never change `mem_addr`. `mem_sel` after an edge is 1 exactly when `sel_n` was low and `sel` was high at that edge.
- R8: A clear, load or count may follow any other action at the very next edge. The access selected at the clearing edge is presented with address 0, with no cycle lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_addr | input | AW | External address, taken when the strobe is active |
| strobe_n | input | 1 | Active-low load strobe |
| cnt_en_n | input | 1 | Active-low count enable |
| clr_n | input | 1 | Active-low counter clear, highest priority |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| mem_addr | output | AW | Registered address for this cycle's access |
| mem_sel | output | 1 | Registered access qualifier |

## Verification
Every result is due exactly one rising edge after its controls are sampled, since each path goes through a single register. The bench changes the inputs on the falling edge. It checks the outputs a short time after the next rising edge and updates its own arithmetic model at that same point. A 4-bit configuration is swept exhaustively: every starting address, every combination of the three controls, and every chip-select pairing. After that come the directed checks: the wrap from the top address, and back-to-back sequences of clear, count and load with no gap between them.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_STEP = 2'd2,
    ACT_ZERO = 2'd3
  } bac_act_e;
endpackage

// File: rtl/bac_decode.sv
module bac_decode
  import bac_pkg::*;
(
  input  logic     clr_n,
  input  logic     strobe_n,
  input  logic     cnt_en_n,
  output bac_act_e act
);
  // Fixed priority: clear > load > step > hold
  always_comb begin
    if (!clr_n)         act = ACT_ZERO;
    else if (!strobe_n) act = ACT_LOAD;
    else if (!cnt_en_n) act = ACT_STEP;
    else                act = ACT_HOLD;
  end
endmodule

// File: rtl/bac_next.sv
module bac_next
  import bac_pkg::*;
#(
  parameter int AW = 17
) (
  input  bac_act_e      act,
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] ext,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] ONE = AW'(1);

  // Modulo 2^AW increment gives the wrap for free
  always_comb begin
    unique case (act)
      ACT_ZERO: nxt = '0;
      ACT_LOAD: nxt = ext;
      ACT_STEP: nxt = cur + ONE;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import bac_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ext_addr,
  input  logic          strobe_n,
  input  logic          cnt_en_n,
  input  logic          clr_n,
  input  logic          sel_n,
  input  logic          sel,
  output logic [AW-1:0] mem_addr,
  output logic          mem_sel
);
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  bac_act_e      act;
  logic [AW-1:0] nxt;
  logic [AW-1:0] addr_q;
  logic          sel_q;

  bac_decode u_dec (
    .clr_n    (clr_n),
    .strobe_n (strobe_n),
    .cnt_en_n (cnt_en_n),
    .act      (act)
  );

  bac_next #(.AW(AW)) u_nxt (
    .act (act),
    .cur (addr_q),
    .ext (ext_addr),
    .nxt (nxt)
  );

  // Chip selects qualify the access only; they never reach the counter
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      addr_q <= nxt;
      sel_q  <= ~sel_n & sel;
    end
  end

  assign mem_addr = addr_q;
  assign mem_sel  = sel_q;

  p_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> mem_addr == '0);

  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !strobe_n) |=> mem_addr == $past(ext_addr));

  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_n && strobe_n && !cnt_en_n && mem_addr != TOP)
      |=> mem_addr == $past(mem_addr) + AW'(1));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_n && strobe_n && cnt_en_n) |=> $stable(mem_addr));

  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_n && strobe_n && !cnt_en_n && mem_addr == TOP) |=> mem_addr == '0);

  p_sel_r7: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && sel) |=> mem_sel);

  p_desel_r7: assert property (@(posedge clk) disable iff (rst)
    (sel_n || !sel) |=> !mem_sel);
endmodule

// File: tb/burst_addr_ctr_test.sv
module burst_addr_ctr_test;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic          strobe_n = 1'b1;
  logic          cnt_en_n = 1'b1;
  logic          clr_n = 1'b1;
  logic          sel_n = 1'b1;
  logic          sel = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_sel;

  int tests = 0;
  int fails = 0;
  int model = 0;

  always #10 clk = ~clk;

  burst_addr_ctr #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .strobe_n(strobe_n),
    .cnt_en_n(cnt_en_n), .clr_n(clr_n), .sel_n(sel_n), .sel(sel),
    .mem_addr(mem_addr), .mem_sel(mem_sel)
  );

  task automatic check(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Drive at falling edge, check just after the next rising edge
  task automatic step(input int c, input int s, input int e, input int ex,
                      input int sn, input int sh, input string req);
    int exp_sel;
    @(negedge clk);
    clr_n = c[0]; strobe_n = s[0]; cnt_en_n = e[0];
    ext_addr = ex[AW-1:0]; sel_n = sn[0]; sel = sh[0];
    @(posedge clk);
    #2;
    if (c == 0)      model = 0;
    else if (s == 0) model = ex % N;
    else if (e == 0) model = (model + 1) % N;
    exp_sel = (sn == 0 && sh == 1) ? 1 : 0;
    check(req, int'(mem_addr), model);
    check("R7 sel", int'(mem_sel), exp_sel);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 addr", int'(mem_addr), 0);
    check("R1 sel", int'(mem_sel), 0);
    @(negedge clk);
    rst = 1'b0;
    model = 0;

    // Exhaustive sweep: start address x controls x chip selects
    for (int a = 0; a < N; a++)
      for (int k = 0; k < 8; k++)
        for (int q = 0; q < 4; q++) begin
          int c, s, e, ex;
          string tag;
          c = (k >> 2) & 1; s = (k >> 1) & 1; e = k & 1;
          ex = (a * 5 + 3 + q) % N;
          step(1, 0, q & 1, a, 1, 0, "R3 load");
          if (c == 0)      tag = "R2 clear";
          else if (s == 0) tag = "R3 load";
          else if (e == 0) tag = (a == N - 1) ? "R6 wrap" : "R4 step";
          else             tag = "R5 hold";
          step(c, s, e, ex, q & 1, (q >> 1) & 1, tag);
        end

    // Wrap through the full space by counting
    step(1, 0, 1, N - 2, 0, 1, "R3 load");
    step(1, 1, 0, 0, 0, 1, "R4 step");
    step(1, 1, 0, 0, 0, 1, "R6 wrap");
    check("R6 zero", int'(mem_addr), 0);
    for (int i = 0; i < N; i++) step(1, 1, 0, 7, 1, 1, "R6 full lap");

    // Back-to-back actions, no gaps
    step(1, 0, 0, 9, 0, 1, "R8 load");
    step(0, 0, 0, 5, 0, 1, "R8 clear");
    check("R8 zero", int'(mem_addr), 0);
    step(1, 1, 0, 12, 0, 1, "R8 step");
    check("R8 one", int'(mem_addr), 1);
    step(0, 1, 1, 3, 0, 1, "R8 clear");
    step(1, 0, 1, 11, 0, 1, "R8 load");
    step(1, 1, 1, 2, 1, 0, "R5 hold");
    check("R5 kept", int'(mem_addr), 11);

    // Reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check("R1 addr", int'(mem_addr), 0);
    check("R1 sel", int'(mem_sel), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule